// File: doc/BRIEF.md
# Strobed Parallel Port with Handshake Interrupts

This block sits between a processor bus and two external devices. One device pushes bytes into the block. It holds an active-low strobe low for at least one clock, and the falling edge captures the input byte and raises a buffer-full line. When the strobe returns high and input interrupts are enabled, the block requests service. The processor drops the request as soon as it starts reading the input register. The buffer-full line clears when that read completes.

The other device pulls bytes out. A processor write to the output register drives the byte onto the output pins and asserts an active-low output-full line. The device acknowledges with an active-low pulse. The falling edge of the acknowledge releases the full line, and the rising edge raises an output interrupt if it is enabled. The next write to the output register clears that interrupt.

Back-pressure on the input side is carried by the buffer-full line. A device must not strobe again until the line is low, because a strobe that arrives while the buffer is full is dropped. On the output side, the processor watches the output-full status bit before writing. A write always replaces the held byte. Interrupt enables and two spare general-purpose output lines are changed one bit at a time by a set/reset command word.

Top module: `strobed_port`

## Requirements
- R1: After reset, ibf is 0, obf_n is 1, both interrupt outputs are 0, pb_out and gp_out are 0, and the status register (address 2) reads 8'h02.
- R2: In the clock where stb_n is first sampled low, if ibf is 0, the byte on pa_in is captured into the input register and ibf becomes 1.
- R3: A falling stb_n while ibf is 1 is ignored: the input register keeps its earlier byte.
- R4: intr_in is 1 only while stb_n is high, ibf is 1 and the input interrupt enable (status bit 4) is 1. A pending request that is masked appears once the enable is set.
- R5: A falling rd_n at address 0 clears intr_in on the next clock. ibf stays 1 until rd_n is sampled high again, then clears.
- R6: The rising edge of wr_n at address 1 loads wdata onto pb_out and drives obf_n to 0.
- R7: A falling ack_n sets obf_n to 1. The following rising ack_n raises intr_out if the output interrupt enable (status bit 2) is 1, and leaves it 0 otherwise.
- R8: A falling wr_n at address 1 clears intr_out on the next clock.
- R9: A write to address 3 with wdata[7]=0 sets the bit selected by wdata[3:1] to the value in wdata[0]. Index 4 is the input interrupt enable, index 2 is the output interrupt enable, and indices 6 and 7 drive gp_out[0] and gp_out[1].
- R10: A write to address 3 with wdata[7]=1, or any write to address 2, changes no state.
- R11: Status (address 2) bits, from 7 down to 0, are gp_out[1], gp_out[0], ibf, input enable, intr_in, output enable, obf_n and intr_out.
- R12: rdata shows the input register at address 0, the last written output byte at address 1, and zero at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low, data taken on its rising edge |
| wdata | input | DATA_W | Processor write data |
| rdata | output | DATA_W | Processor read data, selected by addr |
| pa_in | input | DATA_W | Input device data |
| stb_n | input | 1 | Input device strobe, active low |
| ibf | output | 1 | Input buffer full |
| intr_in | output | 1 | Input interrupt request |
| pb_out | output | DATA_W | Output device data |
| ack_n | input | 1 | Output device acknowledge, active low |
| obf_n | output | 1 | Output buffer full, active low |
| intr_out | output | 1 | Output interrupt request |
| gp_out | output | 2 | Spare lines set by command |

## Verification
The input channel is driven with all-zero, all-one, alternating and single-bit bytes. This separates a correct capture from stuck, swapped or shifted data bits. Each byte is followed by a read, so the early drop of the interrupt at the start of the read is seen apart from the later clear of buffer-full. The output channel replays the same byte table through write and acknowledge pulses, which checks the write, release and interrupt order on every round. Directed cases cover the following: a second strobe into a full buffer, a pending interrupt while masked, an acknowledge with the enable off, command words with the top bit set, writes to the status address, and the spare-line commands.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [1:0] {
    RS_IN   = 2'd0,
    RS_OUT  = 2'd1,
    RS_STAT = 2'd2,
    RS_CMD  = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int ST_INTR_B = 0;
  localparam int ST_OBF_N  = 1;
  localparam int ST_INTE_B = 2;
  localparam int ST_INTR_A = 3;
  localparam int ST_INTE_A = 4;
  localparam int ST_IBF    = 5;
  localparam int ST_GP0    = 6;
  localparam int ST_GP1    = 7;
  localparam int ST_W      = 8;

  // command word fields
  localparam int CMD_MODE_BIT = 7;
  localparam int CMD_SEL_LO   = 1;
  localparam int CMD_SEL_W    = 3;
  localparam int CMD_VAL_BIT  = 0;
  localparam int NUM_GP       = 2;
endpackage

// File: rtl/pp_edge.sv
module pp_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= sig;
  end

  assign fall = prev_q & ~sig;
  assign rise = ~prev_q & sig;
endmodule

// File: rtl/pp_in_chan.sv
module pp_in_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_n,
  input  logic [DW-1:0] din,
  input  logic          rd_start,
  input  logic          rd_done,
  input  logic          inte,
  output logic [DW-1:0] data_q,
  output logic          full,
  output logic          intr
);
  logic stb_fall, stb_rise;
  logic pend_q;

  pp_edge #(.IDLE(1'b1)) u_stb_edge (
    .clk(clk), .rst_n(rst_n), .sig(stb_n), .fall(stb_fall), .rise(stb_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (rd_done) begin
      full <= 1'b0;
    end else if (stb_fall && !full) begin
      full   <= 1'b1;
      data_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (rd_start || rd_done) pend_q <= 1'b0;
    else if (stb_rise && full)    pend_q <= 1'b1;
  end

  assign intr = pend_q & inte & stb_n;
endmodule

// File: rtl/pp_out_chan.sv
module pp_out_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_n,
  input  logic          wr_start,
  input  logic          wr_done,
  input  logic [DW-1:0] wdata,
  input  logic          inte,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          intr
);
  logic ack_fall, ack_rise;
  logic pend_q;

  pp_edge #(.IDLE(1'b1)) u_ack_edge (
    .clk(clk), .rst_n(rst_n), .sig(ack_n), .fall(ack_fall), .rise(ack_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_n <= 1'b1;
      dout   <= '0;
    end else if (wr_done) begin
      full_n <= 1'b0;
      dout   <= wdata;
    end else if (ack_fall) begin
      full_n <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (wr_start)            pend_q <= 1'b0;
    else if (ack_rise && full_n)  pend_q <= 1'b1;
  end

  assign intr = pend_q & inte;
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DW-1:0]     wdata,
  output logic              inte_a,
  output logic              inte_b,
  output logic [NUM_GP-1:0] gp_out
);
  localparam int NBITS = 1 << CMD_SEL_W;

  logic [CMD_SEL_W-1:0] sel;
  logic                 val;
  logic                 take;

  assign sel  = wdata[CMD_SEL_LO +: CMD_SEL_W];
  assign val  = wdata[CMD_VAL_BIT];
  assign take = cmd_wr & ~wdata[CMD_MODE_BIT];

  logic [NBITS-1:0] bits_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (i == ST_INTE_A || i == ST_INTE_B || i == ST_GP0 || i == ST_GP1) begin : g_used
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          bits_q[i] <= 1'b0;
        else if (take && sel == CMD_SEL_W'(i)) bits_q[i] <= val;
      end
    end else begin : g_unused
      assign bits_q[i] = 1'b0;
    end
  end

  assign inte_a = bits_q[ST_INTE_A];
  assign inte_b = bits_q[ST_INTE_B];
  assign gp_out = {bits_q[ST_GP1], bits_q[ST_GP0]};
endmodule

// File: rtl/strobed_port.sv
module strobed_port
  import pport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pa_in,
  input  logic              stb_n,
  output logic              ibf,
  output logic              intr_in,
  output logic [DATA_W-1:0] pb_out,
  input  logic              ack_n,
  output logic              obf_n,
  output logic              intr_out,
  output logic [1:0]        gp_out
);
  logic rd_fall, rd_rise, wr_fall, wr_rise;
  logic inte_a, inte_b;
  logic [DATA_W-1:0] in_q;
  logic [ST_W-1:0]   status;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(addr);

  pp_edge #(.IDLE(1'b1)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .sig(rd_n), .fall(rd_fall), .rise(rd_rise)
  );
  pp_edge #(.IDLE(1'b1)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .sig(wr_n), .fall(wr_fall), .rise(wr_rise)
  );

  pp_in_chan #(.DW(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .din(pa_in),
    .rd_start(rd_fall && sel == RS_IN), .rd_done(rd_rise && sel == RS_IN),
    .inte(inte_a), .data_q(in_q), .full(ibf), .intr(intr_in)
  );

  pp_out_chan #(.DW(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n),
    .wr_start(wr_fall && sel == RS_OUT), .wr_done(wr_rise && sel == RS_OUT),
    .wdata(wdata), .inte(inte_b), .dout(pb_out), .full_n(obf_n), .intr(intr_out)
  );

  pp_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wr_rise && sel == RS_CMD), .wdata(wdata),
    .inte_a(inte_a), .inte_b(inte_b), .gp_out(gp_out)
  );

  always_comb begin
    status            = '0;
    status[ST_INTR_B] = intr_out;
    status[ST_OBF_N]  = obf_n;
    status[ST_INTE_B] = inte_b;
    status[ST_INTR_A] = intr_in;
    status[ST_INTE_A] = inte_a;
    status[ST_IBF]    = ibf;
    status[ST_GP0]    = gp_out[0];
    status[ST_GP1]    = gp_out[1];
  end

  always_comb begin
    unique case (sel)
      RS_IN:   rdata = in_q;
      RS_OUT:  rdata = pb_out;
      RS_STAT: rdata = DATA_W'(status);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/strobed_port_chk.sv
module strobed_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    addr,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] wdata,
  input logic          stb_n,
  input logic          ack_n,
  input logic          ibf,
  input logic          intr_in,
  input logic          obf_n,
  input logic          intr_out,
  input logic [DW-1:0] pb_out
);
  a_r2_strobe_fills: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_n) && !ibf && !($rose(rd_n) && addr == 2'd0)) |=> ibf);

  a_r4_intr_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    intr_in |-> (stb_n && ibf));

  a_r5_read_drops_intr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) && addr == 2'd0) |=> !intr_in);

  a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_n) && addr == 2'd1) |=> (!obf_n && pb_out == $past(wdata)));

  a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_n) && !($rose(wr_n) && addr == 2'd1)) |=> obf_n);

  a_r8_write_drops_intr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_n) && addr == 2'd1) |=> !intr_out);
endmodule

bind strobed_port strobed_port_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
  .wdata(wdata), .stb_n(stb_n), .ack_n(ack_n), .ibf(ibf), .intr_in(intr_in),
  .obf_n(obf_n), .intr_out(intr_out), .pb_out(pb_out)
);

// File: tb/strobed_port_tb.sv
module strobed_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT = 6;
  localparam logic [7:0] PATS [NPAT] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       rd_n = 1'b1, wr_n = 1'b1, stb_n = 1'b1, ack_n = 1'b1;
  logic [7:0] wdata = 8'h00, pa_in = 8'h00;
  logic [7:0] rdata, pb_out;
  logic       ibf, intr_in, obf_n, intr_out;
  logic [1:0] gp_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobed_port u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .stb_n(stb_n), .ibf(ibf),
    .intr_in(intr_in), .pb_out(pb_out), .ack_n(ack_n), .obf_n(obf_n),
    .intr_out(intr_out), .gp_out(gp_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_n = 1'b0;
    cyc();
    wr_n = 1'b1;
    cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] last_out;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 ibf", {7'd0, ibf}, 8'h00);
    chk("R1 obf_n", {7'd0, obf_n}, 8'h01);
    chk("R1 intr", {6'd0, intr_in, intr_out}, 8'h00);
    chk("R1 pb_out", pb_out, 8'h00);
    chk("R1 gp_out", {6'd0, gp_out}, 8'h00);
    peek(2'd2, v);
    chk("R1 R11 status", v, 8'h02);

    // R9 enables via command: select 4 value 1, select 2 value 1
    bus_write(2'd3, 8'h09);
    bus_write(2'd3, 8'h05);
    peek(2'd2, v);
    chk("R9 R11 enables in status", v, 8'h16);

    // table walk: input channel
    for (int i = 0; i < NPAT; i++) begin
      pa_in = PATS[i]; stb_n = 1'b0;
      cyc();
      chk("R2 ibf set", {7'd0, ibf}, 8'h01);
      chk("R4 no intr while strobe low", {7'd0, intr_in}, 8'h00);
      stb_n = 1'b1; pa_in = ~PATS[i];
      cyc();
      chk("R4 intr after strobe release", {7'd0, intr_in}, 8'h01);
      addr = 2'd0; rd_n = 1'b0;
      cyc();
      chk("R5 intr drops on read start", {7'd0, intr_in}, 8'h00);
      chk("R5 ibf held during read", {7'd0, ibf}, 8'h01);
      chk("R2 R12 captured byte", rdata, PATS[i]);
      rd_n = 1'b1;
      cyc();
      chk("R5 ibf clears after read", {7'd0, ibf}, 8'h00);
    end

    // table walk: output channel
    for (int i = 0; i < NPAT; i++) begin
      addr = 2'd1; wdata = PATS[i]; wr_n = 1'b0;
      cyc();
      chk("R8 write drops intr_out", {7'd0, intr_out}, 8'h00);
      wr_n = 1'b1;
      cyc();
      chk("R6 pb_out", pb_out, PATS[i]);
      chk("R6 obf_n low", {7'd0, obf_n}, 8'h00);
      ack_n = 1'b0;
      cyc();
      chk("R7 obf_n released", {7'd0, obf_n}, 8'h01);
      chk("R7 no intr before ack rise", {7'd0, intr_out}, 8'h00);
      ack_n = 1'b1;
      cyc();
      chk("R7 intr_out after ack", {7'd0, intr_out}, 8'h01);
    end
    last_out = PATS[NPAT-1];

    // R3 strobe into a full buffer is dropped
    pa_in = 8'h11; stb_n = 1'b0; cyc(); stb_n = 1'b1; cyc();
    pa_in = 8'h22; stb_n = 1'b0; cyc();
    chk("R4 intr masked by low strobe", {7'd0, intr_in}, 8'h00);
    stb_n = 1'b1; cyc();
    chk("R4 intr back after strobe high", {7'd0, intr_in}, 8'h01);
    addr = 2'd0; rd_n = 1'b0; cyc();
    chk("R3 first byte kept", rdata, 8'h11);
    rd_n = 1'b1; cyc();

    // R4 pending input while disabled, then enabled
    bus_write(2'd3, 8'h08);
    pa_in = 8'h3C; stb_n = 1'b0; cyc(); stb_n = 1'b1; cyc();
    chk("R4 no intr with enable off", {7'd0, intr_in}, 8'h00);
    chk("R4 ibf with enable off", {7'd0, ibf}, 8'h01);
    bus_write(2'd3, 8'h09);
    chk("R4 intr once enabled", {7'd0, intr_in}, 8'h01);
    addr = 2'd0; rd_n = 1'b0; cyc(); rd_n = 1'b1; cyc();
    chk("R5 ibf clear", {7'd0, ibf}, 8'h00);

    // R7 output enable off: ack gives no interrupt
    bus_write(2'd3, 8'h04);
    bus_write(2'd1, 8'hC3);
    last_out = 8'hC3;
    ack_n = 1'b0; cyc(); ack_n = 1'b1; cyc();
    chk("R7 no intr_out with enable off", {7'd0, intr_out}, 8'h00);
    chk("R7 obf_n high", {7'd0, obf_n}, 8'h01);

    // R10 ignored writes
    bus_write(2'd3, 8'h88);
    peek(2'd2, v);
    chk("R10 mode-bit command ignored", v, 8'h12);
    bus_write(2'd2, 8'hFF);
    peek(2'd2, v);
    chk("R10 status write ignored", v, 8'h12);
    chk("R10 pb_out untouched", pb_out, last_out);

    // R9 spare lines
    bus_write(2'd3, 8'h0D);
    bus_write(2'd3, 8'h0F);
    chk("R9 gp_out both set", {6'd0, gp_out}, 8'h03);
    bus_write(2'd3, 8'h0C);
    chk("R9 gp_out bit0 cleared", {6'd0, gp_out}, 8'h02);
    peek(2'd2, v);
    chk("R11 status with spare line", v, 8'h92);

    // R12 read mux
    peek(2'd3, v);
    chk("R12 address 3 reads zero", v, 8'h00);
    peek(2'd1, v);
    chk("R12 address 1 reads output byte", v, last_out);

    finish_run();
  end
endmodule